// File: doc/BRIEF.md
# Lockable PWM Configuration Register

This block holds the 8-bit configuration word of a six-output (three pair) PWM unit and sits on a plain synchronous register bus: address, write enable, write data and combinational read data. The word carries a write-lock bit, a timebase-mode bit that selects one shared timebase or three separate ones, an alignment select for each pair and an independent/complementary select for each pair. The decoded bits go straight to the PWM core.

Two bits are one-way: once software sets the lock or the multi-timebase mode, only reset clears them. While the lock is set, every write to the configuration word is dropped, and the lock output tells other protectable registers to do the same. The block also guards a window of per-generator registers. That window only exists in multi-timebase mode. In single-timebase mode, writes to the window are not forwarded and reads from it return zero.

Top module: `pwm_cfg_lock`

## Requirements
- R1: After reset the stored word is 0x00. All control outputs are 0, and a read of offset 0x00 returns 0x00.
- R2: The lock bit (bit 7) is sticky. Once set, writing 0 to it leaves it at 1 until reset.
- R3: The multi-timebase bit (bit 6) is sticky. Once set, writing 0 to it leaves it at 1 until reset.
- R4: While unlocked, a write to offset 0x00 loads bits 5..0 from the write data and ORs bits 7 and 6 into their stored values. A write that sets the lock still loads its own data; the lock applies from the next cycle.
- R5: While the lock bit is set, writes to offset 0x00 leave the stored word unchanged.
- R6: While the multi-timebase bit is 0, writes to offsets 0x28 to 0x37 do not raise `winWrEn`, and reads there return 0.
- R7: While the multi-timebase bit is 1, a write in 0x28 to 0x37 raises `winWrEn` in the same cycle, and a read there returns `winRdData`.
- R8: Bits 5, 4 and 3 are the alignment selects for pairs C, B and A; `alignEdge[2:0]` is ordered {C,B,A}, and 0 means center-aligned and 1 means edge-aligned. While the multi-timebase bit is 0, pairs B and C follow pair A's bit. Bits 2, 1 and 0 drive `indepMode[2:0]` ({C,B,A}) directly.
- R9: A read of offset 0x00 returns the stored word as written, at any time, including while locked. Reads of offsets outside 0x00 and 0x28 to 0x37 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 6 | Register offset |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data (combinational) |
| winRdData | input | 8 | Read data from the generator register window |
| winWrEn | output | 1 | Gated write strobe for the window registers |
| wrProtect | output | 1 | Lock state for all protectable registers |
| multiTimebase | output | 1 | 1 = three independent timebases |
| alignEdge | output | 3 | Per-pair alignment {C,B,A}, 1 = edge |
| indepMode | output | 3 | Per-pair independent select {C,B,A} |

## Verification
The hardest case to reach is a locked register whose multi-timebase bit is also set. The alignment outputs must keep their separate per-pair values there, while clearing writes bounce off both sticky bits. The stimulus table builds up that state in order. First it sets the mode, then it locks with a write that also changes the alignment bits, and only then does it try to clear the bits and rewrite them. A directed sequence then writes again in the cycle right after the locking write. This checks that the lock takes hold exactly one cycle later.

// File: rtl/pwm_cfg_pkg.sv
package pwm_cfg_pkg;
  localparam int CFG_W       = 8;
  localparam int PAIRS       = 3;
  localparam int BIT_LOCK    = 7;
  localparam int BIT_MULTI   = 6;
  localparam int ALIGN_LO    = 3;
  localparam int INDEP_LO    = 0;

  typedef struct packed {
    logic cfgSel;
    logic cfgWrOk;
    logic winSel;
    logic winWrOk;
  } cfgStrobe_t;
endpackage

// File: rtl/pwm_cfg_ctrl.sv
module pwm_cfg_ctrl
  import pwm_cfg_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int CFG_OFS = 'h00,
  parameter int WIN_LO  = 'h28,
  parameter int WIN_HI  = 'h37
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              lockQ,
  input  logic              multiQ,
  output cfgStrobe_t        strb
);
  localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_OFS);
  localparam logic [ADDR_W-1:0] LO_A  = ADDR_W'(WIN_LO);
  localparam logic [ADDR_W-1:0] HI_A  = ADDR_W'(WIN_HI);

  logic hitCfg, hitWin;

  always_comb begin
    hitCfg       = (busAddr == CFG_A);
    hitWin       = (busAddr >= LO_A) && (busAddr <= HI_A);
    strb.cfgSel  = hitCfg;
    strb.winSel  = hitWin;
    strb.cfgWrOk = busWrEn && hitCfg && !lockQ;
    strb.winWrOk = busWrEn && hitWin && multiQ;
  end
endmodule

// File: rtl/pwm_cfg_dp.sv
module pwm_cfg_dp
  import pwm_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  cfgStrobe_t       strb,
  input  logic [CFG_W-1:0] busWrData,
  input  logic [CFG_W-1:0] winRdData,
  output logic [CFG_W-1:0] cfgQ,
  output logic [CFG_W-1:0] busRdData,
  output logic [PAIRS-1:0] alignEdge,
  output logic [PAIRS-1:0] indepMode
);
  logic multiQ;
  assign multiQ = cfgQ[BIT_MULTI];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (strb.cfgWrOk) begin
      cfgQ[BIT_LOCK]    <= cfgQ[BIT_LOCK]  | busWrData[BIT_LOCK];
      cfgQ[BIT_MULTI]   <= cfgQ[BIT_MULTI] | busWrData[BIT_MULTI];
      cfgQ[BIT_MULTI-1:0] <= busWrData[BIT_MULTI-1:0];
    end
  end

  always_comb begin
    if (strb.cfgSel)                busRdData = cfgQ;
    else if (strb.winSel && multiQ) busRdData = winRdData;
    else                            busRdData = '0;
  end

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign indepMode[p] = cfgQ[INDEP_LO + p];
    if (p == 0) begin : g_master
      assign alignEdge[p] = cfgQ[ALIGN_LO];
    end else begin : g_slave
      assign alignEdge[p] = multiQ ? cfgQ[ALIGN_LO + p] : cfgQ[ALIGN_LO];
    end
  end

  assert_lock_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    cfgQ[BIT_LOCK] |=> cfgQ[BIT_LOCK]);
  assert_multi_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    cfgQ[BIT_MULTI] |=> cfgQ[BIT_MULTI]);
  assert_locked_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    cfgQ[BIT_LOCK] |=> $stable(cfgQ));
  assert_win_read_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!multiQ && strb.winSel) |-> (busRdData == '0));
  assert_align_follow_R8: assert property (@(posedge clk) disable iff (!rstN)
    !multiQ |-> (alignEdge[1] == alignEdge[0] && alignEdge[2] == alignEdge[0]));
endmodule

// File: rtl/pwm_cfg_lock.sv
module pwm_cfg_lock
  import pwm_cfg_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int CFG_OFS = 'h00,
  parameter int WIN_LO  = 'h28,
  parameter int WIN_HI  = 'h37
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  input  logic [7:0]        winRdData,
  output logic              winWrEn,
  output logic              wrProtect,
  output logic              multiTimebase,
  output logic [2:0]        alignEdge,
  output logic [2:0]        indepMode
);
  cfgStrobe_t       strb;
  logic [CFG_W-1:0] cfgQ;

  pwm_cfg_ctrl #(
    .ADDR_W(ADDR_W), .CFG_OFS(CFG_OFS), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
  ) i_ctrl (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .lockQ(cfgQ[BIT_LOCK]),
    .multiQ(cfgQ[BIT_MULTI]),
    .strb(strb)
  );

  pwm_cfg_dp i_dp (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .busWrData(busWrData),
    .winRdData(winRdData),
    .cfgQ(cfgQ),
    .busRdData(busRdData),
    .alignEdge(alignEdge),
    .indepMode(indepMode)
  );

  assign winWrEn       = strb.winWrOk;
  assign wrProtect     = cfgQ[BIT_LOCK];
  assign multiTimebase = cfgQ[BIT_MULTI];

  assert_win_block_R6: assert property (@(posedge clk) disable iff (!rstN)
    !multiTimebase |-> !winWrEn);
  assert_win_pass_R7: assert property (@(posedge clk) disable iff (!rstN)
    winWrEn |-> (busWrEn && multiTimebase));
endmodule

// File: tb/test_pwm_cfg_lock.sv
module test_pwm_cfg_lock;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rstN = 0;
  logic [5:0] busAddr = '0;
  logic       busWrEn = 0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic [7:0] winRdData = '0;
  logic       winWrEn, wrProtect, multiTimebase;
  logic [2:0] alignEdge, indepMode;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_cfg_lock i_pwm_cfg_lock (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .winRdData(winRdData),
    .winWrEn(winWrEn), .wrProtect(wrProtect), .multiTimebase(multiTimebase),
    .alignEdge(alignEdge), .indepMode(indepMode)
  );

  typedef struct packed {
    logic [5:0] wAddr;
    logic [7:0] wData;
    logic       expWin;
    logic [5:0] rAddr;
    logic [7:0] winRd;
    logic [7:0] expRd;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{6'h28, 8'h55, 1'b0, 6'h28, 8'hAA, 8'h00, 4'd6},  // R6 window closed
    '{6'h00, 8'h3F, 1'b0, 6'h00, 8'h00, 8'h3F, 4'd4},  // R4 plain load
    '{6'h00, 8'h00, 1'b0, 6'h00, 8'h00, 8'h00, 4'd4},  // R4 clear low bits
    '{6'h00, 8'h40, 1'b0, 6'h00, 8'h00, 8'h40, 4'd3},  // R3 set mode
    '{6'h00, 8'h00, 1'b0, 6'h00, 8'h00, 8'h40, 4'd3},  // R3 clear attempt
    '{6'h37, 8'h11, 1'b1, 6'h37, 8'h99, 8'h99, 4'd7},  // R7 window open
    '{6'h30, 8'h00, 1'b1, 6'h38, 8'h99, 8'h00, 4'd9},  // R9 above window
    '{6'h00, 8'h98, 1'b0, 6'h00, 8'h00, 8'hD8, 4'd4},  // R4 locking write loads
    '{6'h00, 8'h27, 1'b0, 6'h00, 8'h00, 8'hD8, 4'd5},  // R5 ignored
    '{6'h00, 8'h00, 1'b0, 6'h00, 8'h00, 8'hD8, 4'd2},  // R2 clear attempt
    '{6'h28, 8'h01, 1'b1, 6'h27, 8'h5A, 8'h00, 4'd9}   // R9 below window
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [5:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1;
    @(posedge clk); @(negedge clk);
    busWrEn = 0;
  endtask

  task automatic doReset();
    rstN = 0; busWrEn = 0;
    @(negedge clk); @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();
    // R1 reset state
    busAddr = 6'h00; #1;
    check("R1 read", busRdData, 8'h00);
    check("R1 ctrl", {wrProtect, multiTimebase, alignEdge, indepMode}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      busAddr = VECS[i].wAddr; busWrData = VECS[i].wData; busWrEn = 1; #1;
      check($sformatf("R%0d vec%0d wr", VECS[i].req, i), {7'd0, winWrEn}, {7'd0, VECS[i].expWin});
      @(posedge clk); @(negedge clk);
      busWrEn = 0; busAddr = VECS[i].rAddr; winRdData = VECS[i].winRd; #1;
      check($sformatf("R%0d vec%0d rd", VECS[i].req, i), busRdData, VECS[i].expRd);
      if (i == 7) begin
        check("R8 separate align", {5'd0, alignEdge}, 8'h03);
        check("R2 lock out", {7'd0, wrProtect}, 8'h01);
      end
    end

    // R8 pairs follow A in single timebase
    doReset();
    doWrite(6'h00, 8'h08);
    check("R8 follow A=1", {5'd0, alignEdge}, 8'h07);
    doWrite(6'h00, 8'h21);
    check("R8 follow A=0", {5'd0, alignEdge}, 8'h00);
    check("R8 indep", {5'd0, indepMode}, 8'h01);
    busAddr = 6'h00; #1;
    check("R9 raw read", busRdData, 8'h21);
    doWrite(6'h00, 8'h48);
    check("R8 multi align", {5'd0, alignEdge}, 8'h01);
    check("R3 mode out", {7'd0, multiTimebase}, 8'h01);

    // R4/R5 lock applies from the next cycle, back-to-back writes
    doReset();
    busAddr = 6'h00; busWrData = 8'h85; busWrEn = 1;
    @(posedge clk); @(negedge clk);
    busWrData = 8'h3A;
    @(posedge clk); @(negedge clk);
    busWrEn = 0; #1;
    check("R4 lock write data", busRdData, 8'h85);
    check("R5 next write dropped", {5'd0, indepMode}, 8'h05);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule